// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache misses that are still being serviced by memory, so a non-blocking cache can go on accepting requests while block fills are outstanding. Each tracking entry records which block is in flight, where in the data buffer it will land, and a per-word record: whether a requester waits for that word, whether the word sits in the input stack, which bytes have already been written over it, and which requester asked for it. Every request is compared against all live entries at once. A match, called a previous-miss hit, is classified from the addressed word's record, so the tag control can decide whether to forward, wait or write.

The request port uses valid/ready. `req_ready` drops only when the tag array reports a miss and no entry is free; a lookup that the tag array reports as a hit is always accepted. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the caller must hold the request until then. The status outputs are combinational and describe the request shown in the same cycle. The update port is driven by the memory return logic. It carries no back-pressure: every cycle with `upd_valid` high applies one operation to one word of one entry. Its read-side outputs always show the record of the entry and word that `upd_entry`/`upd_word` select. Two diagnostic vectors can force entry valid bits.

Addresses are word addresses. The low `log2(WORDS)` bits select the word within a block, and the rest form the block address.

Top module: `mshr_file`

## Requirements
- R1: With the default four entries, `req_ready` is low only while `req_miss` is high and all four entries are valid. Otherwise it is high.
- R2: A lookup compares the request block address with every entry that is valid and not obsolete. `pm_hit` and `pm_entry` (lowest matching index) report a match. `pm_multi` rises when two or more entries match.
- R3: On a previous-miss hit, the status reports the addressed word as follows. `pm_partial` is set when its byte code is nonzero. `pm_total` is set when the code is all ones (4'hF). `pm_instack` is set when the word is in the input stack. `pm_asked` is set when its send bit is set. With no hit, all four flags are 0.
- R4: An accepted miss takes the lowest-index free entry and does the following: sets valid, clears obsolete, stores both addresses, clears the stack bits, byte codes and ids, and sets only the send bit of the requested word with the requester id in that word's slot.
- R5: A prefetch request sets no send bit and stores no id, both on allocation and on a previous-miss hit.
- R6: An allocation sets the byte codes of every word to all ones in each other valid entry whose buffer address equals the new one.
- R7: A miss that matches a live entry marks that entry obsolete. The obsolete entry no longer matches, so later lookups find the new entry.
- R8: An accepted read lookup (`req_miss`=0) that hits a word with no send bit, no stack bit and a byte code that is not all ones sets that send bit and stores the requester id. In every other case the id is left unchanged.
- R9: A write request (`req_wr`=1) ORs `req_be` into the hit word's byte code and never sets a send bit. A write miss loads `req_be` into the requested word's code.
- R10: Update operation codes are 1 = stacked (set the stack bit, clear the send bit), 2 = written (clear the stack bit, set the code to all ones, count one word), 3 = dropped (count one word) and 0 = none. The entry frees itself after it has counted `WORDS` words.
- R11: `upd_send`, `upd_id` and `upd_cba` show the selected entry's record. `upd_discard` is high when that entry is obsolete or the word's code is all ones. `upd_err` is high when `upd_valid` addresses an entry that is not valid.
- R12: When a lookup hits the word that a stacked update targets in the same cycle, `pm_instack` reads 1 and the send bit is not set.
- R13: `diag_set[i]` forces entry i valid, and `diag_clr[i]` forces it invalid. The clear wins over the set, over an allocation and over a retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Request word address |
| req_cba | input | CBA_W | Data-buffer block address chosen for a miss |
| req_id | input | ID_W | Requester identification |
| req_miss | input | 1 | Tag array reports a miss |
| req_pref | input | 1 | Request is a prefetch |
| req_wr | input | 1 | Request is a partial write |
| req_be | input | BYTES | Byte enables of a write |
| pm_hit | output | 1 | Previous-miss hit |
| pm_entry | output | IDX_W | Index of the hit entry |
| pm_partial | output | 1 | Hit word partly written |
| pm_total | output | 1 | Hit word totally written |
| pm_instack | output | 1 | Hit word in the input stack |
| pm_asked | output | 1 | Hit word already requested |
| pm_multi | output | 1 | More than one entry matched |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_op | input | 2 | Update operation code |
| upd_entry | input | IDX_W | Entry addressed by the update side |
| upd_word | input | OFF_W | Word addressed by the update side |
| upd_send | output | 1 | Selected word's send bit |
| upd_id | output | ID_W | Selected word's requester id |
| upd_cba | output | CBA_W | Selected entry's buffer address |
| upd_discard | output | 1 | Returning word must not update the buffer |
| upd_err | output | 1 | Update addressed an invalid entry |
| diag_set | input | N_ENT | Force entry valid |
| diag_clr | input | N_ENT | Force entry invalid |

## Verification
A lookup and a memory return can meet on the same word in one cycle. The bench provokes this by driving a read lookup of an unrequested word together with a stacked update of that same word. It then checks that the status already shows the word as stacked, and in the next cycle it reads the word back through the update side to confirm that no send bit was set. The bench also lets a retiring drop share a cycle with a stalled miss, to show that the freed entry is offered only on the following cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_STACK = 2'd1,
    UPD_WRITE = 2'd2,
    UPD_DROP  = 2'd3
  } upd_op_e;

  typedef struct packed {
    logic partial;
    logic total;
    logic instack;
    logic asked;
  } pm_status_t;

endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int BYTES = 4,
  parameter int ID_W  = 4,
  parameter int BLK_W = 14,
  parameter int CBA_W = 6,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = OFF_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             alloc_en,
  input  logic [BLK_W-1:0]                 alloc_blk,
  input  logic [CBA_W-1:0]                 alloc_cba,
  input  logic [OFF_W-1:0]                 alloc_word,
  input  logic [ID_W-1:0]                  alloc_id,
  input  logic                             alloc_ask,
  input  logic                             alloc_wr,
  input  logic [BYTES-1:0]                 alloc_be,
  input  logic                             mark_obs,
  input  logic                             purge,
  input  logic                             ask_en,
  input  logic [OFF_W-1:0]                 ask_word,
  input  logic [ID_W-1:0]                  ask_id,
  input  logic                             wmask_en,
  input  logic [OFF_W-1:0]                 wmask_word,
  input  logic [BYTES-1:0]                 wmask_be,
  input  logic                             upd_en,
  input  upd_op_e                          upd_op,
  input  logic [OFF_W-1:0]                 upd_word,
  input  logic                             diag_set,
  input  logic                             diag_clr,
  output logic                             valid_o,
  output logic                             obs_o,
  output logic [BLK_W-1:0]                 blk_o,
  output logic [CBA_W-1:0]                 cba_o,
  output logic [WORDS-1:0]                 send_o,
  output logic [WORDS-1:0]                 stack_o,
  output logic [WORDS-1:0][BYTES-1:0]      pw_o,
  output logic [WORDS-1:0][ID_W-1:0]       id_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic                        valid_q, obs_q;
  logic [BLK_W-1:0]            blk_q;
  logic [CBA_W-1:0]            cba_q;
  logic [WORDS-1:0]            send_q, stack_q;
  logic [WORDS-1:0][BYTES-1:0] pw_q;
  logic [WORDS-1:0][ID_W-1:0]  id_q;
  logic [CNT_W-1:0]            cnt_q;
  logic                        counts;

  assign counts = upd_en && (upd_op == UPD_WRITE || upd_op == UPD_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      obs_q   <= 1'b0;
      blk_q   <= '0;
      cba_q   <= '0;
      send_q  <= '0;
      stack_q <= '0;
      pw_q    <= '0;
      id_q    <= '0;
      cnt_q   <= '0;
    end else begin
      if (alloc_en) begin
        valid_q <= 1'b1;
        obs_q   <= 1'b0;
        blk_q   <= alloc_blk;
        cba_q   <= alloc_cba;
        send_q  <= '0;
        stack_q <= '0;
        pw_q    <= '0;
        id_q    <= '0;
        cnt_q   <= '0;
        if (alloc_ask) begin
          send_q[alloc_word] <= 1'b1;
          id_q[alloc_word]   <= alloc_id;
        end
        if (alloc_wr) pw_q[alloc_word] <= alloc_be;
      end else begin
        if (mark_obs) obs_q <= 1'b1;
        if (ask_en) begin
          send_q[ask_word] <= 1'b1;
          id_q[ask_word]   <= ask_id;
        end
        if (wmask_en) pw_q[wmask_word] <= pw_q[wmask_word] | wmask_be;
        if (purge) pw_q <= '1;
        if (upd_en && upd_op == UPD_STACK) begin
          stack_q[upd_word] <= 1'b1;
          send_q[upd_word]  <= 1'b0;
        end
        if (upd_en && upd_op == UPD_WRITE) begin
          stack_q[upd_word] <= 1'b0;
          pw_q[upd_word]    <= '1;
        end
        if (counts) begin
          if (cnt_q == LAST) begin
            valid_q <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      if (diag_set) valid_q <= 1'b1;
      if (diag_clr) valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign obs_o   = obs_q;
  assign blk_o   = blk_q;
  assign cba_o   = cba_q;
  assign send_o  = send_q;
  assign stack_o = stack_q;
  assign pw_o    = pw_q;
  assign id_o    = id_q;

  // R4: a fresh allocation starts live, current and with nothing stacked
  p_alloc_init_r4: assert property (@(posedge clk) disable iff (rst)
    alloc_en && !diag_clr |=> valid_q && !obs_q && stack_q == '0);

  // R6: a purged entry reports every word as fully overwritten
  p_purge_r6: assert property (@(posedge clk) disable iff (rst)
    purge && !alloc_en |=> &pw_q);

  // R7: obsolete stays set until the entry is handed out again
  p_obs_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    obs_q && !alloc_en |=> obs_q);

  // R10: a stacked word no longer waits to be sent
  p_stack_send_r10: assert property (@(posedge clk) disable iff (rst)
    upd_en && upd_op == UPD_STACK && !alloc_en |=> !send_q[$past(upd_word)]);

  // R10: the last counted word frees the entry
  p_retire_r10: assert property (@(posedge clk) disable iff (rst)
    counts && cnt_q == LAST && !alloc_en && !diag_set |=> !valid_q);

endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup
  import mshr_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int WORDS = 4,
  parameter int BYTES = 4,
  parameter int BLK_W = 14,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 active,
  input  logic [BLK_W-1:0]                     req_blk,
  input  logic [OFF_W-1:0]                     req_word,
  input  logic [N_ENT-1:0]                     valid,
  input  logic [N_ENT-1:0]                     obs,
  input  logic [N_ENT-1:0][BLK_W-1:0]          blk,
  input  logic [N_ENT-1:0][WORDS-1:0]          send,
  input  logic [N_ENT-1:0][WORDS-1:0]          stack,
  input  logic [N_ENT-1:0][WORDS-1:0][BYTES-1:0] pw,
  input  logic                                 upd_valid,
  input  upd_op_e                              upd_op,
  input  logic [IDX_W-1:0]                     upd_entry,
  input  logic [OFF_W-1:0]                     upd_word,
  output logic [N_ENT-1:0]                     match,
  output logic                                 hit,
  output logic [IDX_W-1:0]                     hit_idx,
  output logic                                 multi,
  output pm_status_t                           status
);

  logic [BYTES-1:0] code;
  logic             fwd;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = valid[g] && !obs[g] && (blk[g] == req_blk);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit   = active && (match != '0);
  assign multi = active && ((match & (match - 1'b1)) != '0);
  assign code  = pw[hit_idx][req_word];
  assign fwd   = upd_valid && upd_op == UPD_STACK &&
                 upd_entry == hit_idx && upd_word == req_word;

  always_comb begin
    status = '0;
    if (hit) begin
      status.partial = code != '0;
      status.total   = &code;
      status.instack = stack[hit_idx][req_word] || fwd;
      status.asked   = send[hit_idx][req_word];
    end
  end

  // R7: the reported entry is live and current
  p_hit_live_r7: assert property (@(posedge clk) disable iff (rst)
    hit |-> valid[hit_idx] && !obs[hit_idx]);

  // R3: flags only accompany a previous-miss hit
  p_flags_gated_r3: assert property (@(posedge clk) disable iff (rst)
    !hit |-> status == '0);

endmodule

// File: rtl/mshr_alloc.sv
module mshr_alloc #(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ENT-1:0] valid,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);

  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_any = !(&valid);

  // R4: the offered entry is really free
  p_free_ok_r4: assert property (@(posedge clk) disable iff (rst)
    free_any |-> !valid[free_idx]);

endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int WORDS  = 4,
  parameter int BYTES  = 4,
  parameter int ADDR_W = 16,
  parameter int CBA_W  = 6,
  parameter int ID_W   = 4,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CBA_W-1:0]  req_cba,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_miss,
  input  logic              req_pref,
  input  logic              req_wr,
  input  logic [BYTES-1:0]  req_be,
  output logic              pm_hit,
  output logic [IDX_W-1:0]  pm_entry,
  output logic              pm_partial,
  output logic              pm_total,
  output logic              pm_instack,
  output logic              pm_asked,
  output logic              pm_multi,
  input  logic              upd_valid,
  input  logic [1:0]        upd_op,
  input  logic [IDX_W-1:0]  upd_entry,
  input  logic [OFF_W-1:0]  upd_word,
  output logic              upd_send,
  output logic [ID_W-1:0]   upd_id,
  output logic [CBA_W-1:0]  upd_cba,
  output logic              upd_discard,
  output logic              upd_err,
  input  logic [N_ENT-1:0]  diag_set,
  input  logic [N_ENT-1:0]  diag_clr
);

  logic [N_ENT-1:0]                        e_valid, e_obs;
  logic [N_ENT-1:0][BLK_W-1:0]             e_blk;
  logic [N_ENT-1:0][CBA_W-1:0]             e_cba;
  logic [N_ENT-1:0][WORDS-1:0]             e_send, e_stack;
  logic [N_ENT-1:0][WORDS-1:0][BYTES-1:0]  e_pw;
  logic [N_ENT-1:0][WORDS-1:0][ID_W-1:0]   e_id;

  logic [BLK_W-1:0] req_blk;
  logic [OFF_W-1:0] req_word;
  upd_op_e          op;
  logic             fire, do_alloc, use_hit, ask_ok;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [N_ENT-1:0] match, alloc_vec, obs_vec, purge_vec, ask_vec, wm_vec, upd_vec;
  pm_status_t       st;

  assign req_blk  = req_addr[ADDR_W-1:OFF_W];
  assign req_word = req_addr[OFF_W-1:0];
  assign op       = upd_op_e'(upd_op);

  mshr_alloc #(.N_ENT(N_ENT)) u_alloc (
    .clk(clk), .rst(rst), .valid(e_valid),
    .free_any(free_any), .free_idx(free_idx)
  );

  mshr_lookup #(.N_ENT(N_ENT), .WORDS(WORDS), .BYTES(BYTES), .BLK_W(BLK_W)) u_look (
    .clk(clk), .rst(rst), .active(req_valid),
    .req_blk(req_blk), .req_word(req_word),
    .valid(e_valid), .obs(e_obs), .blk(e_blk),
    .send(e_send), .stack(e_stack), .pw(e_pw),
    .upd_valid(upd_valid), .upd_op(op), .upd_entry(upd_entry), .upd_word(upd_word),
    .match(match), .hit(pm_hit), .hit_idx(pm_entry), .multi(pm_multi), .status(st)
  );

  assign pm_partial = st.partial;
  assign pm_total   = st.total;
  assign pm_instack = st.instack;
  assign pm_asked   = st.asked;

  assign req_ready = !req_miss || free_any;
  assign fire      = req_valid && req_ready;
  assign do_alloc  = fire && req_miss;
  assign use_hit   = fire && !req_miss && pm_hit && !pm_multi;
  assign ask_ok    = !req_wr && !req_pref && !st.asked && !st.instack && !st.total;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign alloc_vec[g] = do_alloc && free_idx == IDX_W'(g);
    assign obs_vec[g]   = do_alloc && match[g];
    assign purge_vec[g] = do_alloc && e_valid[g] && e_cba[g] == req_cba;
    assign ask_vec[g]   = use_hit && pm_entry == IDX_W'(g) && ask_ok;
    assign wm_vec[g]    = use_hit && pm_entry == IDX_W'(g) && req_wr;
    assign upd_vec[g]   = upd_valid && upd_entry == IDX_W'(g);

    mshr_entry #(
      .WORDS(WORDS), .BYTES(BYTES), .ID_W(ID_W), .BLK_W(BLK_W), .CBA_W(CBA_W)
    ) u_ent (
      .clk(clk), .rst(rst),
      .alloc_en(alloc_vec[g]), .alloc_blk(req_blk), .alloc_cba(req_cba),
      .alloc_word(req_word), .alloc_id(req_id),
      .alloc_ask(!req_wr && !req_pref), .alloc_wr(req_wr), .alloc_be(req_be),
      .mark_obs(obs_vec[g]), .purge(purge_vec[g]),
      .ask_en(ask_vec[g]), .ask_word(req_word), .ask_id(req_id),
      .wmask_en(wm_vec[g]), .wmask_word(req_word), .wmask_be(req_be),
      .upd_en(upd_vec[g]), .upd_op(op), .upd_word(upd_word),
      .diag_set(diag_set[g]), .diag_clr(diag_clr[g]),
      .valid_o(e_valid[g]), .obs_o(e_obs[g]), .blk_o(e_blk[g]), .cba_o(e_cba[g]),
      .send_o(e_send[g]), .stack_o(e_stack[g]), .pw_o(e_pw[g]), .id_o(e_id[g])
    );
  end

  assign upd_send    = e_send[upd_entry][upd_word];
  assign upd_id      = e_id[upd_entry][upd_word];
  assign upd_cba     = e_cba[upd_entry];
  assign upd_discard = e_obs[upd_entry] || (&e_pw[upd_entry][upd_word]);
  assign upd_err     = upd_valid && !e_valid[upd_entry];

  // R1: back-pressure only for a miss with every entry taken
  p_stall_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |-> req_miss && (&e_valid));

  // R4: at most one entry is handed out per cycle
  p_one_alloc_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_vec));

  // R12: a word caught while being stacked is not marked as requested
  p_fwd_r12: assert property (@(posedge clk) disable iff (rst)
    use_hit && upd_valid && op == UPD_STACK && upd_entry == pm_entry &&
    upd_word == req_word && diag_clr == '0
    |=> !e_send[$past(pm_entry)][$past(req_word)]);

endmodule

// File: tb/sim_mshr_file.sv
`timescale 1ns/1ps
module sim_mshr_file;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_miss, req_pref, req_wr;
  logic [15:0] req_addr;
  logic [5:0]  req_cba;
  logic [3:0]  req_id, req_be;
  logic        pm_hit, pm_partial, pm_total, pm_instack, pm_asked, pm_multi;
  logic [1:0]  pm_entry;
  logic        upd_valid;
  logic [1:0]  upd_op, upd_entry, upd_word;
  logic        upd_send, upd_discard, upd_err;
  logic [3:0]  upd_id;
  logic [5:0]  upd_cba;
  logic [3:0]  diag_set, diag_clr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mshr_file u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cba(req_cba), .req_id(req_id), .req_miss(req_miss),
    .req_pref(req_pref), .req_wr(req_wr), .req_be(req_be),
    .pm_hit(pm_hit), .pm_entry(pm_entry), .pm_partial(pm_partial),
    .pm_total(pm_total), .pm_instack(pm_instack), .pm_asked(pm_asked),
    .pm_multi(pm_multi),
    .upd_valid(upd_valid), .upd_op(upd_op), .upd_entry(upd_entry),
    .upd_word(upd_word), .upd_send(upd_send), .upd_id(upd_id),
    .upd_cba(upd_cba), .upd_discard(upd_discard), .upd_err(upd_err),
    .diag_set(diag_set), .diag_clr(diag_clr)
  );

  typedef struct packed {
    logic [4:0]  rq;
    logic        rv, mi, wr, pf;
    logic [15:0] addr;
    logic [5:0]  cba;
    logic [3:0]  id, be;
    logic        uv;
    logic [1:0]  op, ue, uw;
    logic        xr, xh;
    logic [1:0]  xe;
    logic [3:0]  xf;   // {partial, total, instack, asked}
    logic        cu, xs;
    logic [3:0]  xid;
    logic        xd, xerr;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{4,  1,1,0,0, 'h0101, 5,3,0, 0,0,0,0, 1,0,0,0,       0,0,0,0,0}, // R4 first miss takes entry 0
    '{3,  1,0,0,0, 'h0101, 0,7,0, 0,0,0,0, 1,1,0,'b0001,  0,0,0,0,0}, // R3 asked word
    '{8,  1,0,0,0, 'h0102, 0,9,0, 0,0,0,0, 1,1,0,'b0000,  0,0,0,0,0}, // R8 asks word 2
    '{5,  1,0,0,1, 'h0103, 0,0,0, 0,0,0,0, 1,1,0,'b0000,  0,0,0,0,0}, // R5 prefetch hit
    '{5,  1,0,0,0, 'h0103, 0,2,0, 0,0,0,0, 1,1,0,'b0000,  0,0,0,0,0}, // R5 still unasked
    '{5,  1,1,0,1, 'h0200, 6,0,0, 0,0,0,0, 1,0,0,0,       0,0,0,0,0}, // R5 prefetch miss
    '{5,  1,0,0,0, 'h0200, 0,1,0, 0,0,0,0, 1,1,1,'b0000,  0,0,0,0,0}, // R5 no send bit set
    '{11, 0,0,0,0, 'h0000, 0,0,0, 1,1,0,1, 1,0,0,0,       1,1,3,0,0}, // R11 stack e0 w1
    '{10, 1,0,0,0, 'h0101, 0,7,0, 0,0,0,1, 1,1,0,'b0010,  1,0,3,0,0}, // R10 stacked clears send
    '{10, 0,0,0,0, 'h0000, 0,0,0, 1,2,0,1, 1,0,0,0,       1,0,3,0,0}, // R10 write e0 w1
    '{3,  1,0,1,0, 'h0101, 0,0,3, 0,0,0,1, 1,1,0,'b1100,  1,0,3,1,0}, // R3 totally written
    '{9,  1,0,1,0, 'h0100, 0,0,3, 0,0,0,0, 1,1,0,'b0000,  0,0,0,0,0}, // R9 partial write
    '{9,  1,0,0,0, 'h0100, 0,5,0, 0,0,0,0, 1,1,0,'b1000,  0,0,0,0,0}, // R9 partial reported
    '{8,  0,0,0,0, 'h0000, 0,0,0, 0,0,0,0, 1,0,0,0,       1,1,5,0,0}, // R8 id recorded
    '{6,  1,1,0,0, 'h0300, 5,4,0, 0,0,0,0, 1,0,0,0,       0,0,0,0,0}, // R6 same buffer block
    '{6,  1,0,0,0, 'h0102, 0,9,0, 0,0,0,2, 1,1,0,'b1101,  1,1,9,1,0}, // R6 purged codes
    '{4,  1,0,0,0, 'h0300, 0,4,0, 0,0,2,0, 1,1,2,'b0001,  1,1,4,0,0}, // R4 entry 2 fields
    '{7,  1,1,0,0, 'h0200, 7,8,0, 0,0,0,0, 1,1,1,'b0001,  0,0,0,0,0}, // R7 realloc same block
    '{7,  1,0,0,0, 'h0201, 0,1,0, 0,0,3,0, 1,1,3,'b0000,  1,1,8,0,0}, // R7 new entry wins
    '{11, 0,0,0,0, 'h0000, 0,0,0, 0,0,1,0, 1,0,0,0,       1,1,1,1,0}, // R11 obsolete discards
    '{1,  1,1,0,0, 'h0400, 9,6,0, 0,0,0,0, 0,0,0,0,       0,0,0,0,0}, // R1 full stall
    '{1,  1,1,0,0, 'h0400, 9,6,0, 1,3,1,0, 0,0,0,0,       1,1,1,1,0}, // R1 stall + drop
    '{10, 0,0,0,0, 'h0000, 0,0,0, 1,3,1,1, 1,0,0,0,       1,0,0,1,0}, // R10 drop w1
    '{10, 0,0,0,0, 'h0000, 0,0,0, 1,3,1,2, 1,0,0,0,       1,0,0,1,0}, // R10 drop w2
    '{10, 1,1,0,0, 'h0400, 9,6,0, 1,3,1,3, 0,0,0,0,       1,0,0,1,0}, // R10 retire same cycle
    '{10, 1,1,0,0, 'h0400, 9,6,0, 0,0,0,0, 1,0,0,0,       0,0,0,0,0}, // R10 freed entry reused
    '{4,  0,0,0,0, 'h0000, 0,0,0, 0,0,1,0, 1,0,0,0,       1,1,6,0,0}, // R4 lowest free = 1
    '{12, 1,0,0,0, 'h0401, 0,2,0, 1,1,1,1, 1,1,1,'b0010,  1,0,0,0,0}, // R12 hit while stacking
    '{12, 1,0,0,0, 'h0401, 0,2,0, 0,0,1,1, 1,1,1,'b0010,  1,0,0,0,0}  // R12 send not set
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_miss = 0; req_pref = 0; req_wr = 0;
    req_addr = '0; req_cba = '0; req_id = '0; req_be = '0;
    upd_valid = 0; upd_op = 0; upd_entry = 0; upd_word = 0;
    diag_set = '0; diag_clr = '0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1 R2 R11: reset state
    upd_valid = 1; upd_op = 3; upd_entry = 0;
    #1;
    check("R1 reset ready", {31'd0, req_ready}, 32'd1);
    check("R2 reset no hit", {30'd0, pm_hit, pm_multi}, 32'd0);
    check("R11 update to invalid entry", {31'd0, upd_err}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = VEC[i].rv; req_miss = VEC[i].mi; req_wr = VEC[i].wr;
      req_pref = VEC[i].pf; req_addr = VEC[i].addr; req_cba = VEC[i].cba;
      req_id = VEC[i].id; req_be = VEC[i].be;
      upd_valid = VEC[i].uv; upd_op = VEC[i].op;
      upd_entry = VEC[i].ue; upd_word = VEC[i].uw;
      #1;
      check($sformatf("R%0d row %0d request side", VEC[i].rq, i),
            {23'd0, req_ready, pm_hit, (pm_hit ? pm_entry : 2'd0),
             pm_partial, pm_total, pm_instack, pm_asked, pm_multi},
            {23'd0, VEC[i].xr, VEC[i].xh, VEC[i].xe, VEC[i].xf, 1'b0});
      if (VEC[i].cu)
        check($sformatf("R%0d row %0d update side", VEC[i].rq, i),
              {25'd0, upd_send, upd_id, upd_discard, upd_err},
              {25'd0, VEC[i].xs, VEC[i].xid, VEC[i].xd, VEC[i].xerr});
    end

    // R11: buffer address of entry 1 (allocated with 9)
    @(negedge clk);
    idle();
    upd_entry = 1;
    #1;
    check("R11 buffer address", {26'd0, upd_cba}, 32'd9);

    // R2 R13: two forced entries with the same block give a multiple match
    do_reset();
    diag_set = 4'b0011;
    @(negedge clk);
    idle();
    req_valid = 1; req_addr = 16'h0000;
    #1;
    check("R2 multiple match", {30'd0, pm_hit, pm_multi}, 32'd3);

    // R13: clear beats set on entry 0
    @(negedge clk);
    idle();
    diag_set = 4'b0001; diag_clr = 4'b0001;
    @(negedge clk);
    idle();
    req_valid = 1; req_addr = 16'h0000;
    #1;
    check("R13 clear beats set", {29'd0, pm_hit, pm_multi, pm_entry == 2'd1}, 32'd5);

    // R13: clear beats allocation of entry 0
    @(negedge clk);
    idle();
    req_valid = 1; req_miss = 1; req_addr = 16'h0500; req_cba = 6'd3; req_id = 4'd2;
    diag_clr = 4'b0001;
    #1;
    check("R1 miss with free entry", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    idle();
    req_valid = 1; req_addr = 16'h0500;
    #1;
    check("R13 clear beats allocation", {31'd0, pm_hit}, 32'd0);

    @(negedge clk);
    idle();
    summary();
    $finish;
  end

endmodule